// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block translates addresses for a game console cartridge that holds more program and pattern ROM than the console can address directly. It snoops CPU write cycles in the upper half of the CPU address space. The data byte of each such write is stored in one of several small bank registers. From those registers it drives three outputs:

- the upper program-ROM address bits for each CPU read,
- the upper pattern-ROM address bits for each picture-unit fetch,
- the nametable address line that sets how the console's two internal nametables are mirrored.

A strap input picks one of two chip revisions. The two revisions route the register-select address lines differently, and they interpret the pattern bank numbers differently.

Program space has four 8 KB windows. The windows at CPU `$8000` and `$A000` can be switched. The windows at `$C000` and `$E000` always show the last two banks of the ROM. Pattern space has eight 1 KB windows. The bank number of each pattern window is loaded as two separate 4-bit halves.

Top module: `cart_bank_mapper`

## Requirements
- R1: When `rst` is high at a clock edge, every bank register clears to 0 and the mirroring mode clears to vertical (0).
- R2: A write whose address has upper nibble `$8` loads `cpu_data[3:0]` as the bank of CPU window `$8000`. A write with upper nibble `$A` loads the bank of window `$A000` in the same way. In both cases address bits 1:0 may take any value. For a read, `prg_hi` shows the stored bank of the window selected by CPU A14:A13 (00 or 01).
- R3: For CPU A14:A13 = 10, `prg_hi` is the second-to-last bank (all ones minus one). For A14:A13 = 11, it is the last bank (all ones).
- R4: A write with upper nibble `$9` loads the mirroring mode from `cpu_data[1:0]`. The mode sets `ciram_a10` as follows:
  - 0: equal to PPU A10
  - 1: equal to PPU A11
  - 2: constant 0
  - 3: constant 1
- R5: Writes with upper nibble `$B`, `$C`, `$D` and `$E` load the pattern window pairs 0/1, 2/3, 4/5 and 6/7. In the normal revision, A1 = 0 selects the even window of the pair and A1 = 1 selects the odd window. A0 = 0 loads the low nibble of the bank number and A0 = 1 loads the high nibble. `chr_hi` shows the bank of the window selected by PPU A12:A10.
- R6: With `strap_alt` = 1, the roles of A0 and A1 are swapped before decode. For example, address `$B002` then loads the high nibble of window 0.
- R7: With `strap_alt` = 1, `chr_hi` is the stored 8-bit bank number shifted right by one, so bit 7 reads 0. The stored value itself is kept, and it shows in full again when the strap returns to 0.
- R8: A register is loaded only when all three of these hold at the clock edge:
  - `cpu_wr_stb` = 1,
  - `cpu_rw` = 0 (0 = write, 1 = read),
  - `cpu_addr[15]` = 1.

  Writes with upper nibble `$F` change nothing.
- R9: Register decode uses only CPU A15–A12 and A1–A0. Address bits 11:2 have no effect on which register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Revision strap, 1 = alternate revision |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, taken unaltered on writes |
| cpu_rw | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_wr_stb | input | 1 | Single-cycle bus strobe |
| ppu_addr | input | 14 | Picture-unit address bus |
| prg_hi | output | PRG_OUT_W | Program ROM address bits above the 8 KB offset |
| chr_hi | output | 8 | Pattern ROM address bits above the 1 KB offset |
| ciram_a10 | output | 1 | Nametable select line for console video RAM |

## Verification
The assertions rely on three assumptions about the inputs:
- the strobe is high for one clock per bus cycle;
- `cpu_rw` is settled whenever the strobe is high;
- `strap_alt` changes only while no write is being issued.

The bench meets these by changing the strobe, `cpu_rw`, the address and the data only on falling clock edges. It raises the strobe for exactly one cycle and moves the strap only between writes. Outputs are sampled shortly after a falling edge, once the combinational selection has settled.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 14;
    localparam int DATA_W     = 8;
    localparam int NIB_W      = 4;
    localparam int PRG_SEL_W  = 4;
    localparam int CHR_SEL_W  = 2 * NIB_W;
    localparam int CHR_WIN    = 8;
    localparam int CHR_IDX_W  = $clog2(CHR_WIN);

    typedef enum logic [1:0] {
        MIR_VERT = 2'd0,
        MIR_HORZ = 2'd1,
        MIR_LOW  = 2'd2,
        MIR_HIGH = 2'd3
    } mirror_e;

    typedef struct packed {
        logic                 prg0_we;
        logic                 prg1_we;
        logic                 mirr_we;
        logic                 chr_we;
        logic [CHR_IDX_W-1:0] chr_idx;
        logic                 chr_hi_nib;
    } wr_cmd_t;

    typedef struct packed {
        logic [PRG_SEL_W-1:0]               prg0;
        logic [PRG_SEL_W-1:0]               prg1;
        mirror_e                            mirr;
        logic [CHR_WIN-1:0][CHR_SEL_W-1:0]  chr;
    } bank_state_t;

    // Returns {effective A1, effective A0} after the revision swap.
    function automatic logic [1:0] eff_sel(input logic alt, input logic [1:0] a10);
        return alt ? {a10[0], a10[1]} : a10;
    endfunction

endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
    import cbm_pkg::*;
(
    input  logic              strap_alt,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_wr_stb,
    output wr_cmd_t           cmd
);

    logic       wr_ok;
    logic [1:0] sel;
    logic [2:0] page;
    logic [2:0] pair;

    assign wr_ok = cpu_wr_stb & ~cpu_rw & cpu_addr[CPU_AW-1];
    assign sel   = eff_sel(strap_alt, cpu_addr[1:0]);
    assign page  = cpu_addr[CPU_AW-2:CPU_AW-4];
    assign pair  = page - 3'd3;

    always_comb begin
        cmd = '0;
        cmd.chr_idx    = {pair[1:0], sel[1]};
        cmd.chr_hi_nib = sel[0];
        if (wr_ok) begin
            unique case (page)
                3'd0:                   cmd.prg0_we = 1'b1;
                3'd1:                   cmd.mirr_we = 1'b1;
                3'd2:                   cmd.prg1_we = 1'b1;
                3'd3, 3'd4, 3'd5, 3'd6: cmd.chr_we  = 1'b1;
                default:                ;
            endcase
        end
    end

endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       state_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            if (cmd.prg0_we) state_q.prg0 <= wdata[PRG_SEL_W-1:0];
            if (cmd.prg1_we) state_q.prg1 <= wdata[PRG_SEL_W-1:0];
            if (cmd.mirr_we) state_q.mirr <= mirror_e'(wdata[1:0]);
            for (int w = 0; w < CHR_WIN; w++) begin
                if (cmd.chr_we && cmd.chr_idx == CHR_IDX_W'(w)) begin
                    if (cmd.chr_hi_nib)
                        state_q.chr[w][CHR_SEL_W-1:NIB_W] <= wdata[NIB_W-1:0];
                    else
                        state_q.chr[w][NIB_W-1:0] <= wdata[NIB_W-1:0];
                end
            end
        end
    end

    assert_prg0_load_R2: assert property (@(posedge clk) disable iff (rst)
        cmd.prg0_we |=> state_q.prg0 == $past(wdata[PRG_SEL_W-1:0]));

    assert_mirr_load_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.mirr_we |=> state_q.mirr == mirror_e'($past(wdata[1:0])));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(cmd.prg0_we || cmd.prg1_we || cmd.mirr_we || cmd.chr_we) |=> $stable(state_q));

endmodule

// File: rtl/cbm_out_mux.sv
module cbm_out_mux
    import cbm_pkg::*;
#(
    parameter int PRG_OUT_W = 4
)(
    input  bank_state_t          state_q,
    input  logic                 strap_alt,
    input  logic [1:0]           cpu_win,
    input  logic [2:0]           ppu_win,
    input  logic                 ppu_a10,
    input  logic                 ppu_a11,
    output logic [PRG_OUT_W-1:0] prg_hi,
    output logic [CHR_SEL_W-1:0] chr_hi,
    output logic                 ciram_a10
);

    localparam logic [PRG_OUT_W-1:0] LAST_BANK = '1;
    localparam logic [PRG_OUT_W-1:0] NEXT_LAST = LAST_BANK - 1'b1;

    logic [CHR_SEL_W-1:0] chr_raw;

    always_comb begin
        unique case (cpu_win)
            2'd0:    prg_hi = PRG_OUT_W'(state_q.prg0);
            2'd1:    prg_hi = PRG_OUT_W'(state_q.prg1);
            2'd2:    prg_hi = NEXT_LAST;
            default: prg_hi = LAST_BANK;
        endcase
    end

    assign chr_raw = state_q.chr[ppu_win];
    assign chr_hi  = strap_alt ? (chr_raw >> 1) : chr_raw;

    always_comb begin
        unique case (state_q.mirr)
            MIR_VERT: ciram_a10 = ppu_a10;
            MIR_HORZ: ciram_a10 = ppu_a11;
            MIR_LOW:  ciram_a10 = 1'b0;
            default:  ciram_a10 = 1'b1;
        endcase
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_OUT_W = 4
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_alt,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_rw,
    input  logic                 cpu_wr_stb,
    input  logic [13:0]          ppu_addr,
    output logic [PRG_OUT_W-1:0] prg_hi,
    output logic [7:0]           chr_hi,
    output logic                 ciram_a10
);

    wr_cmd_t     cmd;
    bank_state_t state_q;
    logic        unused_bits;

    assign unused_bits = ^{cpu_data[7:4], cpu_addr[11:2], ppu_addr[13], ppu_addr[9:0]};

    cbm_wr_decode u_decode (
        .strap_alt  (strap_alt),
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .cpu_wr_stb (cpu_wr_stb),
        .cmd        (cmd)
    );

    cbm_bank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (cpu_data),
        .state_q (state_q)
    );

    cbm_out_mux #(.PRG_OUT_W(PRG_OUT_W)) u_mux (
        .state_q   (state_q),
        .strap_alt (strap_alt),
        .cpu_win   (cpu_addr[14:13]),
        .ppu_win   (ppu_addr[12:10]),
        .ppu_a10   (ppu_addr[10]),
        .ppu_a11   (ppu_addr[11]),
        .prg_hi    (prg_hi),
        .chr_hi    (chr_hi),
        .ciram_a10 (ciram_a10)
    );

    assert_fixed_last_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[14:13] == 2'b11 |-> prg_hi == {PRG_OUT_W{1'b1}});

    assert_alt_top_bit_R7: assert property (@(posedge clk) disable iff (rst)
        strap_alt |-> chr_hi[7] == 1'b0);

    assert_low_screen_R4: assert property (@(posedge clk) disable iff (rst)
        state_q.mirr == MIR_LOW |-> !ciram_a10);

    assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.prg0_we, cmd.prg1_we, cmd.mirr_we, cmd.chr_we}));

    assert_top_page_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:12] == 4'hF) |-> !(cmd.prg0_we || cmd.prg1_we || cmd.mirr_we || cmd.chr_we));

endmodule

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_alt = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_wr_stb = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [3:0]  prg_hi;
    logic [7:0]  chr_hi;
    logic        ciram_a10;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cart_bank_mapper u_cart_bank_mapper (
        .clk(clk), .rst(rst), .strap_alt(strap_alt), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb),
        .ppu_addr(ppu_addr), .prg_hi(prg_hi), .chr_hi(chr_hi), .ciram_a10(ciram_a10)
    );

    // kind: 0 = prg_hi at CPU addr, 1 = chr_hi at PPU addr, 2 = ciram_a10 at PPU addr
    typedef struct packed {
        logic [15:0] tag;
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [1:0]  kind;
        logic [15:0] qaddr;
        logic [7:0]  expv;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{"R2", 16'h8000, 8'h35, 2'd0, 16'h8000, 8'h05},
        '{"R2", 16'hA003, 8'h0C, 2'd0, 16'hA123, 8'h0C},
        '{"R9", 16'h87F0, 8'h07, 2'd0, 16'h9FFF, 8'h07},
        '{"R3", 16'h0000, 8'hEE, 2'd0, 16'hC000, 8'h0E},
        '{"R3", 16'h4001, 8'h11, 2'd0, 16'hE456, 8'h0F},
        '{"R5", 16'hB000, 8'h03, 2'd1, 16'h0000, 8'h03},
        '{"R5", 16'hB001, 8'h0A, 2'd1, 16'h03FF, 8'hA3},
        '{"R5", 16'hB002, 8'h04, 2'd1, 16'h0400, 8'h04},
        '{"R5", 16'hB003, 8'hFF, 2'd1, 16'h0400, 8'hF4},
        '{"R5", 16'hC001, 8'h01, 2'd1, 16'h0800, 8'h10},
        '{"R5", 16'hC000, 8'h08, 2'd1, 16'h0800, 8'h18},
        '{"R5", 16'hC003, 8'h02, 2'd1, 16'h0C00, 8'h20},
        '{"R5", 16'hD001, 8'h02, 2'd1, 16'h1000, 8'h20},
        '{"R5", 16'hE002, 8'h09, 2'd1, 16'h1C00, 8'h09},
        '{"R9", 16'hEAB3, 8'h06, 2'd1, 16'h1C00, 8'h69},
        '{"R4", 16'h9000, 8'h01, 2'd2, 16'h0800, 8'h01},
        '{"R4", 16'h9003, 8'h03, 2'd2, 16'h0000, 8'h01},
        '{"R4", 16'h9001, 8'h02, 2'd2, 16'h0C00, 8'h00},
        '{"R4", 16'h9002, 8'h00, 2'd2, 16'h0400, 8'h01},
        '{"R4", 16'h9000, 8'h00, 2'd2, 16'h0800, 8'h00},
        '{"R8", 16'hF000, 8'hFF, 2'd0, 16'h8000, 8'h07},
        '{"R8", 16'hF003, 8'h55, 2'd1, 16'h0000, 8'hA3}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic stb);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_wr_stb = stb;
        @(negedge clk);
        cpu_wr_stb = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic probe_cpu(input logic [15:0] a);
        cpu_addr = a; #1;
    endtask

    task automatic probe_ppu(input logic [13:0] a);
        ppu_addr = a; #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        probe_cpu(16'h8000); check("R1", 8'(prg_hi), 8'h00);
        probe_cpu(16'hA000); check("R1", 8'(prg_hi), 8'h00);
        for (int w = 0; w < 8; w++) begin
            probe_ppu(14'(w * 1024)); check("R1", chr_hi, 8'h00);
        end
        probe_ppu(14'h0400); check("R1", 8'(ciram_a10), 8'h01);
        probe_ppu(14'h0800); check("R1", 8'(ciram_a10), 8'h00);

        // Table walk, normal revision
        for (int i = 0; i < NV; i++) begin
            bus(VECS[i].waddr, VECS[i].wdata, 1'b0, 1'b1);
            case (VECS[i].kind)
                2'd0: begin probe_cpu(VECS[i].qaddr); check(string'(VECS[i].tag), 8'(prg_hi), VECS[i].expv); end
                2'd1: begin probe_ppu(VECS[i].qaddr[13:0]); check(string'(VECS[i].tag), chr_hi, VECS[i].expv); end
                default: begin probe_ppu(VECS[i].qaddr[13:0]); check(string'(VECS[i].tag), 8'(ciram_a10), VECS[i].expv); end
            endcase
        end

        // R8: a read cycle with the strobe and a write without the strobe are both ignored
        bus(16'h8000, 8'h09, 1'b1, 1'b1);
        probe_cpu(16'h8000); check("R8", 8'(prg_hi), 8'h07);
        bus(16'hA000, 8'h02, 1'b0, 1'b0);
        probe_cpu(16'hA000); check("R8", 8'(prg_hi), 8'h0C);

        // R6 / R7: alternate revision
        @(negedge clk); strap_alt = 1'b1;
        probe_ppu(14'h1C00); check("R7", chr_hi, 8'h34);
        bus(16'hB002, 8'h06, 1'b0, 1'b1);          // high nibble of window 0
        probe_ppu(14'h0000); check("R6", chr_hi, 8'h31);
        bus(16'hB001, 8'h05, 1'b0, 1'b1);          // low nibble of window 1
        probe_ppu(14'h0400); check("R6", chr_hi, 8'h7A);
        @(negedge clk); strap_alt = 1'b0;
        probe_ppu(14'h0400); check("R7", chr_hi, 8'hF5);
        probe_ppu(14'h0000); check("R7", chr_hi, 8'h63);

        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe_cpu(16'hA000); check("R1", 8'(prg_hi), 8'h00);
        probe_ppu(14'h0400); check("R1", chr_hi, 8'h00);
        probe_ppu(14'h0800); check("R1", 8'(ciram_a10), 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule